// File: doc/BRIEF.md
# Floating Exception Result Selector

This block sits after the arithmetic stage of a vector floating-point element pipeline. For each element it receives the computed 64-bit value, four raw exception flags, the operand format, the exception-enable control bit and the destination register number. It decides what the element write carries: the computed value unchanged, an all-zero word, or a reserved-operand word that encodes which exceptions occurred. Exceptions never trap. The element stream keeps running, and the block only records what happened.

The same element also updates a sticky exception register. This register holds a 4-bit exception-type field and a 16-bit mask of destination registers. Two operation classes change the usual rules. For a compare, the exception type is recorded, but no destination bit is set and no element write is made. For a conversion to integer, the exception is recorded, but the computed value passes through instead of the encoded word. A synchronous clear input empties the exception register.

The write path has one register stage. The exception register updates on the same clock edge as that write.

Top module: `fexc_result_sel`

## Requirements
- R1: An element presented with `elem_valid` high and `is_cmp` low appears after the next rising edge, with `wr_valid` high and `wr_reg` equal to `dest_reg`.
- R2: With no live exception, `wr_data` equals `elem_result` unchanged.
- R3: An underflow alone (flags = 4'b0001) with `exc_en` low writes an all-zero word and leaves the exception register unchanged.
- R4: A live exception writes a 64-bit word with bit 15 set, bits 14:4 zero, all bits above 15 zero, and bits 3:0 equal to the live type. The flags input uses these positions: bit 0 underflow, bit 1 divide by zero, bit 2 reserved operand, bit 3 overflow. Overflow, divide by zero and reserved operand are always live; underflow is live only when `exc_en` is high. The word is the same for format codes F=0, D=1 and G=2.
- R5: When several flags are live together, all of them appear in both the encoded word and the recorded type. An underflow masked by a low `exc_en` appears in neither.
- R6: A live exception ORs its type bits into `exc_type` and sets bit `dest_reg` of `exc_dmask`.
- R7: A compare element (`is_cmp` high) records its live type bits, leaves `exc_dmask` unchanged and produces no write (`wr_valid` low).
- R8: A convert-to-integer element (`is_cvt_int` high) with a live exception writes `elem_result` unchanged and still records its type and destination.
- R9: Recorded bits stay set until `clr_exc`. With `clr_exc` high, after the edge the register holds only the record of the element presented in that same cycle.
- R10: During reset, `wr_valid`, `wr_data`, `wr_reg`, `exc_type` and `exc_dmask` are all zero.
- R11: While `elem_valid` is low, no write is made and the exception register is unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elem_valid | input | 1 | Element present this cycle |
| elem_result | input | 64 | Computed element value |
| exc_flags | input | 4 | Raw flags: 0 underflow, 1 divide by zero, 2 reserved operand, 3 overflow |
| fmt | input | 2 | Operand format: 0 F, 1 D, 2 G |
| exc_en | input | 1 | Enables underflow reporting |
| dest_reg | input | 4 | Destination vector register number |
| is_cmp | input | 1 | Element belongs to a compare |
| is_cvt_int | input | 1 | Element belongs to a convert-to-integer |
| clr_exc | input | 1 | Synchronous clear of the exception register |
| wr_valid | output | 1 | Element write valid |
| wr_data | output | 64 | Value to write |
| wr_reg | output | 4 | Destination register of the write |
| exc_type | output | 4 | Sticky exception types |
| exc_dmask | output | 16 | Sticky destination register mask |

## Verification
The exception register is visible at the ports on every cycle, so a wrong sticky bit shows up one edge after the element that caused it. It stays wrong at every later comparison until the next clear. A wrong write selection shows up in `wr_data` on the edge after the element: a lost type bit in the encoded word, or a pass-through where an encoded word was due. The bench exercises each operation class and each flag combination against a reference model one cycle at a time, so each of these faults is reported in the cycle it first appears.

// File: rtl/fexc_pkg.sv
// Shared types for the floating exception result selector.
// Assumes the flag vector uses the fixed bit positions below.
package fexc_pkg;
    localparam int TYPE_W   = 4;
    localparam int T_UNF    = 0;
    localparam int T_DVZ    = 1;
    localparam int T_ROP    = 2;
    localparam int T_OVF    = 3;
    localparam int SIGN_BIT = 15;

    typedef enum logic [1:0] {
        FMT_F = 2'd0,
        FMT_D = 2'd1,
        FMT_G = 2'd2,
        FMT_X = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WK_PASS = 2'd0,
        WK_ZERO = 2'd1,
        WK_RSVD = 2'd2
    } wkind_e;

    // Lowest exponent bit of the format's 16-bit first word.
    function automatic int exp_lo(input fmt_e f);
        return (f == FMT_G) ? 4 : 7;
    endfunction
endpackage

// File: rtl/fexc_classify.sv
// Decides which exceptions are live and what kind of value to write.
// Assumes the flags are valid only when the caller qualifies them.
module fexc_classify
    import fexc_pkg::*;
(
    input  logic [TYPE_W-1:0] flags,
    input  logic              exc_en,
    input  logic              is_cvt_int,
    output logic [TYPE_W-1:0] live,
    output wkind_e            kind
);
    // Mask underflow by the enable; the other types are always live.
    always_comb begin
        live        = flags;
        live[T_UNF] = flags[T_UNF] & exc_en;
    end

    // Choose pass-through, zero or encoded reserved operand.
    always_comb begin
        if (|live)
            kind = is_cvt_int ? WK_PASS : WK_RSVD;
        else if (flags[T_UNF])
            kind = WK_ZERO;
        else
            kind = WK_PASS;
    end
endmodule

// File: rtl/fexc_encode.sv
// Builds the reserved-operand word: sign set, exponent cleared, type in the low bits.
// Assumes DATA_W is at least 16; every bit not named is driven to zero.
module fexc_encode
    import fexc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        fmt,
    input  logic [TYPE_W-1:0] etype,
    output logic [DATA_W-1:0] word
);
    // Compose the word field by field for the given format.
    always_comb begin
        word = '0;
        word[SIGN_BIT] = 1'b1;
        for (int b = 0; b < SIGN_BIT; b++) begin
            if (b >= exp_lo(fmt_e'(fmt))) word[b] = 1'b0;
        end
        if (fmt_e'(fmt) != FMT_G) begin
            for (int b = TYPE_W; b < 7; b++) word[b] = 1'b0;
        end
        word[TYPE_W-1:0] = etype;
    end
endmodule

// File: rtl/fexc_record.sv
// Sticky exception register: type bits plus a per-destination mask.
// Assumes a clear in the same cycle as an event keeps that event.
module fexc_record
    import fexc_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev_valid,
    input  logic [TYPE_W-1:0] ev_type,
    input  logic              ev_dest_on,
    input  logic [REG_W-1:0]  ev_reg,
    output logic [TYPE_W-1:0] exc_type,
    output logic [NREGS-1:0]  exc_dmask
);
    genvar gi;
    generate
        for (gi = 0; gi < TYPE_W; gi++) begin : g_type
            logic hit;
            assign hit = ev_valid & ev_type[gi];
            // Hold, set or clear one type bit.
            always_ff @(posedge clk) begin
                if (!rst_n)   exc_type[gi] <= 1'b0;
                else if (clr) exc_type[gi] <= hit;
                else          exc_type[gi] <= exc_type[gi] | hit;
            end
        end
        for (gi = 0; gi < NREGS; gi++) begin : g_dest
            logic hit;
            assign hit = ev_valid & ev_dest_on & (ev_reg == REG_W'(gi));
            // Hold, set or clear one destination bit.
            always_ff @(posedge clk) begin
                if (!rst_n)   exc_dmask[gi] <= 1'b0;
                else if (clr) exc_dmask[gi] <= hit;
                else          exc_dmask[gi] <= exc_dmask[gi] | hit;
            end
        end
    endgenerate

    assert_sticky_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((exc_type & $past(exc_type)) == $past(exc_type)));
    assert_sticky_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((exc_dmask & $past(exc_dmask)) == $past(exc_dmask)));
    assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(exc_dmask & ~$past(exc_dmask)) <= 1);
    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !ev_valid |=> (exc_type == '0) && (exc_dmask == '0));
endmodule

// File: rtl/fexc_result_sel.sv
// Top: selects the element write value and updates the sticky exception register.
// Assumes one element per cycle at most; the write is registered once.
module fexc_result_sel
    import fexc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NREGS  = 16,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_valid,
    input  logic [DATA_W-1:0] elem_result,
    input  logic [TYPE_W-1:0] exc_flags,
    input  logic [1:0]        fmt,
    input  logic              exc_en,
    input  logic [REG_W-1:0]  dest_reg,
    input  logic              is_cmp,
    input  logic              is_cvt_int,
    input  logic              clr_exc,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic [REG_W-1:0]  wr_reg,
    output logic [TYPE_W-1:0] exc_type,
    output logic [NREGS-1:0]  exc_dmask
);
    logic [TYPE_W-1:0] live;
    wkind_e            kind;
    logic [DATA_W-1:0] rsvd_word;
    logic [DATA_W-1:0] sel_data;
    logic              ev_valid;

    fexc_classify i_classify (
        .flags      (exc_flags),
        .exc_en     (exc_en),
        .is_cvt_int (is_cvt_int),
        .live       (live),
        .kind       (kind)
    );

    fexc_encode #(.DATA_W(DATA_W)) i_encode (
        .fmt   (fmt),
        .etype (live),
        .word  (rsvd_word)
    );

    assign ev_valid = elem_valid & (|live);

    fexc_record #(.NREGS(NREGS)) i_record (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_exc),
        .ev_valid   (ev_valid),
        .ev_type    (live),
        .ev_dest_on (~is_cmp),
        .ev_reg     (dest_reg),
        .exc_type   (exc_type),
        .exc_dmask  (exc_dmask)
    );

    // Pick the value the element write carries.
    always_comb begin
        case (kind)
            WK_ZERO: sel_data = '0;
            WK_RSVD: sel_data = rsvd_word;
            default: sel_data = elem_result;
        endcase
    end

    // Register the element write; compares never write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_reg   <= '0;
        end else begin
            wr_valid <= elem_valid & ~is_cmp;
            if (elem_valid & ~is_cmp) begin
                wr_data <= sel_data;
                wr_reg  <= dest_reg;
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && !is_cmp |=> wr_valid && (wr_reg == $past(dest_reg)));
    assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && is_cmp |=> !wr_valid);
    assert_rsvd_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && !is_cmp && !is_cvt_int &&
        ((|exc_flags[TYPE_W-1:1]) || (exc_flags[T_UNF] && exc_en))
        |=> wr_data[SIGN_BIT] && (wr_data[SIGN_BIT-1:TYPE_W] == '0) && (wr_data[TYPE_W-1:0] != '0));
    assert_unf_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && !is_cmp && !exc_en && !clr_exc && (exc_flags == 4'b0001)
        |=> (wr_data == '0) && $stable(exc_type) && $stable(exc_dmask));
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid && !clr_exc |=> !wr_valid && $stable(exc_type) && $stable(exc_dmask));
endmodule

// File: tb/test_fexc_result_sel.sv
`timescale 1ns/1ps
module test_fexc_result_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_result = '0;
    logic [3:0]  exc_flags = '0;
    logic [1:0]  fmt = '0;
    logic        exc_en = 1'b0;
    logic [3:0]  dest_reg = '0;
    logic        is_cmp = 1'b0;
    logic        is_cvt_int = 1'b0;
    logic        clr_exc = 1'b0;
    logic        wr_valid;
    logic [63:0] wr_data;
    logic [3:0]  wr_reg;
    logic [3:0]  exc_type;
    logic [15:0] exc_dmask;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    logic        m_valid = 0;
    logic [63:0] m_data  = '0;
    logic [3:0]  m_reg   = '0;
    logic [3:0]  m_type  = '0;
    logic [15:0] m_mask  = '0;

    always #2.5 clk = ~clk;

    fexc_result_sel i_fexc_result_sel (
        .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_result(elem_result),
        .exc_flags(exc_flags), .fmt(fmt), .exc_en(exc_en), .dest_reg(dest_reg),
        .is_cmp(is_cmp), .is_cvt_int(is_cvt_int), .clr_exc(clr_exc),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_reg(wr_reg),
        .exc_type(exc_type), .exc_dmask(exc_dmask)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "wr_valid", 64'(wr_valid), 64'(m_valid));
        if (m_valid) begin
            check(tag, "wr_data", wr_data, m_data);
            check(tag, "wr_reg", 64'(wr_reg), 64'(m_reg));
        end
        check(tag, "exc_type", 64'(exc_type), 64'(m_type));
        check(tag, "exc_dmask", 64'(exc_dmask), 64'(m_mask));
    endtask

    // Behavioural reference: one element per call, results checked after the edge.
    task automatic step(input string tag, input bit v, input logic [63:0] res, input logic [3:0] fl,
                        input logic [1:0] f, input bit en, input logic [3:0] dst,
                        input bit cmp, input bit cvt, input bit clr);
        logic [3:0] lv;
        @(negedge clk);
        elem_valid = v; elem_result = res; exc_flags = fl; fmt = f; exc_en = en;
        dest_reg = dst; is_cmp = cmp; is_cvt_int = cvt; clr_exc = clr;
        @(posedge clk);
        lv = fl;
        if (!en) lv[0] = 1'b0;
        m_valid = v && !cmp;
        if (v && !cmp) begin
            m_reg = dst;
            if (lv != 0 && !cvt)   m_data = 64'h8000 | 64'(lv);
            else if (lv != 0)      m_data = res;
            else if (fl[0])        m_data = 64'd0;
            else                   m_data = res;
        end
        if (clr) begin m_type = '0; m_mask = '0; end
        if (v && lv != 0) begin
            m_type |= lv;
            if (!cmp) m_mask[dst] = 1'b1;
        end
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10", "wr_valid", 64'(wr_valid), 64'd0);
        check("R10", "wr_data", wr_data, 64'd0);
        check("R10", "wr_reg", 64'(wr_reg), 64'd0);
        check("R10", "exc_type", 64'(exc_type), 64'd0);
        check("R10", "exc_dmask", 64'(exc_dmask), 64'd0);
        @(negedge clk) rst_n = 1'b1;

        step("R1",  1, 64'h0123_4567_89AB_CDEF, 4'b0000, 2'd1, 0, 4'd3, 0, 0, 0);
        step("R2",  1, 64'h0000_0000_4080_0000, 4'b0000, 2'd0, 1, 4'd5, 0, 0, 0);
        step("R3",  1, 64'hFFFF_0000_FFFF_0000, 4'b0001, 2'd0, 0, 4'd6, 0, 0, 0);
        step("R4",  1, 64'hDEAD_BEEF_DEAD_BEEF, 4'b1000, 2'd0, 0, 4'd1, 0, 0, 0);
        step("R4",  1, 64'hDEAD_BEEF_DEAD_BEEF, 4'b0010, 2'd1, 0, 4'd2, 0, 0, 0);
        step("R4",  1, 64'hDEAD_BEEF_DEAD_BEEF, 4'b0100, 2'd2, 0, 4'd15, 0, 0, 0);
        step("R4",  1, 64'h1111_2222_3333_4444, 4'b0001, 2'd2, 1, 4'd0, 0, 0, 0);
        step("R9",  1, 64'h0, 4'b0000, 2'd0, 0, 4'd0, 0, 0, 1);
        step("R5",  1, 64'hAAAA_AAAA_AAAA_AAAA, 4'b0110, 2'd1, 0, 4'd7, 0, 0, 0);
        step("R5",  1, 64'h5555_5555_5555_5555, 4'b1001, 2'd2, 0, 4'd8, 0, 0, 0);
        step("R9",  0, 64'h0, 4'b0000, 2'd0, 0, 4'd0, 0, 0, 1);
        step("R7",  1, 64'h7777_7777_7777_7777, 4'b0100, 2'd0, 0, 4'd9, 1, 0, 0);
        step("R8",  1, 64'h0000_0000_8000_0001, 4'b0100, 2'd0, 0, 4'd10, 0, 1, 0);
        step("R8",  1, 64'h0000_0000_0000_0042, 4'b0001, 2'd1, 0, 4'd11, 0, 1, 0);
        step("R11", 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1111, 2'd1, 1, 4'd12, 0, 0, 0);
        step("R9",  1, 64'h0, 4'b1000, 2'd0, 0, 4'd4, 0, 0, 1);
        step("R6",  1, 64'h0, 4'b0010, 2'd0, 0, 4'd13, 0, 0, 0);
        step("R11", 0, 64'h0, 4'b0000, 2'd0, 0, 4'd0, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] r;
            logic [31:0] s;
            r = {$urandom, $urandom};
            s = $urandom;
            step("R6", s[0] | s[1], r, s[5:2], 2'(s[7:6] % 3), s[8], s[12:9],
                 (s[15:13] == 0), (s[18:16] == 0), (s[24:20] == 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule